// File: doc/BRIEF.md
# Graphics Command Packet Framer

The framer accepts a stream of 32-bit graphics command words over a valid/ready input and groups them into whole command packets. The top byte of the first word of each packet selects the command. For most commands a fixed table gives the number of words that follow. Line-strip commands have no fixed length: the packet runs on until a terminator word appears at one of the checked positions. A complete packet goes to a downstream drawing consumer as one parallel bundle of up to `MAX_WORDS` words with a length, using a valid/ready handshake.

Two command families are not passed on as packets. Attribute opcodes store their whole word in an eight-entry register file. The low thirteen bits of a status word are built from two of those registers. Image-transfer opcodes collect three words and then fire a one-cycle start pulse to a separate transfer engine, with the direction, position word and size word. While that engine reports an active host-to-memory transfer, incoming words go straight through to it and the parser does not see them.

Top module: `cmd_packet_framer`

## Requirements
- R1: The opcode is bits 31:24 of a packet's first word, and a fixed-length packet holds 1 + N words. N is 2 for 0x02; 3/6/4/8/5/8/7/11 for the groups of four starting at 0x20/0x24/0x28/0x2C/0x30/0x34/0x38/0x3C; 2 for 0x40-0x47; 3 for 0x50-0x57; 2/3/1/0/1/2/1/2 for the groups of four starting at 0x60/0x64/0x68/0x6C/0x70/0x74/0x78/0x7C; 3 for 0x80; and 0 for every other opcode outside the ranges handled by R2, R3, R6 and R7. The packet is emitted with `pkt_len` equal to its word count, and word k appears in `pkt_words[32k+31:32k]`.
- R2: For opcodes 0x48-0x4F, every word from index 3 onward is tested. The packet ends with, and includes, the first tested word whose bits under mask 0xF000F000 equal 0x50005000. A matching word at index 1 or 2 does not end it.
- R3: For opcodes 0x58-0x5F, only the words at even indices from 4 onward are tested against the same terminator pattern. A matching word at an odd index does not end the packet.
- R4: At most `MAX_WORDS` (16) words of a packet are kept. Words past that count are dropped while the terminator is still searched for, and the packet is then emitted with `pkt_len` equal to `MAX_WORDS`, holding its first 16 words.
- R5: While `pkt_valid` is high and `pkt_ready` is low, the packet outputs hold steady and no input word is accepted into the parser.
- R6: An opcode in 0xA0-0xDF collects exactly three words and emits no packet. It then raises `xfer_start` for one cycle. `xfer_read` is 1 when opcode bits 7:5 are 110, `xfer_pos` carries word 1 and `xfer_size` carries word 2.
- R7: An opcode in 0xE0-0xE7 is a one-word command. It writes its whole word into attribute register (opcode & 7) and emits no packet.
- R8: `status_low[10:0]` equals bits 10:0 of attribute register 1, and `status_low[12:11]` equals bits 1:0 of attribute register 6.
- R9: After reset, attribute register i holds (0xE0+i) << 24, `pkt_valid` and `xfer_start` are low, and `status_low` is zero.
- R10: Until the last word of a packet arrives, the partial packet is kept and nothing is emitted, however long the gap between words.
- R11: While `xfer_wr_active` is high, every input word is accepted and shown on `xfer_data` with `xfer_data_valid`. The parser state and the packet outputs are untouched.
- R12: `xfer_start` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word present |
| in_data | input | 32 | Input command word |
| in_ready | output | 1 | Input word accepted this cycle when valid |
| pkt_valid | output | 1 | Complete packet available |
| pkt_ready | input | 1 | Consumer takes the packet |
| pkt_len | output | CNT_W (5) | Number of valid words in the packet |
| pkt_words | output | MAX_WORDS*32 (512) | Packet words, word 0 in the low 32 bits |
| xfer_start | output | 1 | One-cycle image transfer start |
| xfer_read | output | 1 | Transfer direction: 1 reads memory |
| xfer_pos | output | 32 | Position word of the transfer command |
| xfer_size | output | 32 | Size word of the transfer command |
| xfer_wr_active | input | 1 | Transfer engine is absorbing write data |
| xfer_data_valid | output | 1 | Word routed to the transfer engine |
| xfer_data | output | 32 | Routed word |
| attr_regs | output | 256 | Attribute registers, register i in bits 32i+31:32i |
| status_low | output | 13 | Status bits derived from attribute registers |

## Verification
The finishing of one packet and the start of the next can fall in the same clock edge. In that edge the consumer takes the held bundle while the first word of the following command is written into the same word buffer. That first word may be a plain command, an attribute write or a line-strip head. The bench provokes this by streaming commands back to back while `pkt_ready` is randomly withheld. Each emitted bundle is judged against a queue of expected packets built from the length rules. During stalls it also checks that a held bundle does not change and that the attribute-derived status keeps its expected value.

// File: rtl/cpf_pkg.sv
`timescale 1ns/1ps
package cpf_pkg;

    // How the framer decides where a packet ends
    typedef enum logic [2:0] {
        K_FIXED  = 3'd0,   // table-driven length
        K_STRIP1 = 3'd1,   // terminator tested on every word from index 3
        K_STRIP2 = 3'd2,   // terminator tested on even words from index 4
        K_IMAGE  = 3'd3,   // three words, then hand-off to transfer engine
        K_ATTR   = 3'd4    // single word written to attribute file
    } pkt_kind_e;

    localparam logic [31:0] TERM_MASK = 32'hF000_F000;
    localparam logic [31:0] TERM_VAL  = 32'h5000_5000;
    localparam int          ATTR_N    = 8;
    localparam int          WORD_W    = 32;

endpackage

// File: rtl/cpf_len_decode.sv
`timescale 1ns/1ps
module cpf_len_decode
    import cpf_pkg::*;
(
    input  logic [7:0] opcode,
    output pkt_kind_e  kind,
    output logic [3:0] extra
);

    always_comb begin
        kind  = K_FIXED;
        extra = 4'd0;
        unique case (opcode[7:5])
            3'd0: extra = (opcode == 8'h02) ? 4'd2 : 4'd0;
            3'd1: begin
                unique case (opcode[4:2])
                    3'd0: extra = 4'd3;
                    3'd1: extra = 4'd6;
                    3'd2: extra = 4'd4;
                    3'd3: extra = 4'd8;
                    3'd4: extra = 4'd5;
                    3'd5: extra = 4'd8;
                    3'd6: extra = 4'd7;
                    default: extra = 4'd11;
                endcase
            end
            3'd2: begin
                extra = opcode[4] ? 4'd3 : 4'd2;
                if (opcode[3]) begin
                    kind = opcode[4] ? K_STRIP2 : K_STRIP1;
                end
            end
            3'd3: begin
                unique case (opcode[4:2])
                    3'd0: extra = 4'd2;
                    3'd1: extra = 4'd3;
                    3'd2: extra = 4'd1;
                    3'd3: extra = 4'd0;
                    3'd4: extra = 4'd1;
                    3'd5: extra = 4'd2;
                    3'd6: extra = 4'd1;
                    default: extra = 4'd2;
                endcase
            end
            3'd4: extra = (opcode == 8'h80) ? 4'd3 : 4'd0;
            3'd5, 3'd6: begin
                kind  = K_IMAGE;
                extra = 4'd2;
            end
            default: begin
                if (opcode[4:3] == 2'b00) begin
                    kind = K_ATTR;
                end
            end
        endcase
    end

endmodule

// File: rtl/cpf_attr_file.sv
`timescale 1ns/1ps
module cpf_attr_file
    import cpf_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [2:0]               widx,
    input  logic [WORD_W-1:0]        wdata,
    output logic [ATTR_N*WORD_W-1:0] regs_flat,
    output logic [12:0]              status
);

    logic [ATTR_N-1:0][WORD_W-1:0] regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (we) begin
            regs_d[widx] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ATTR_N; i++) begin
                regs_q[i] <= {8'hE0 + 8'(i), 24'h0};
            end
        end else begin
            regs_q <= regs_d;
        end
    end

    assign regs_flat = regs_q;
    assign status    = {regs_q[6][1:0], regs_q[1][10:0]};

    // R8: a write to register 1 shows in the low status field next cycle
    p_status1_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (we && widx == 3'd1) |=> status[10:0] == $past(wdata[10:0]));

    // R8: a write to register 6 shows in the top status field next cycle
    p_status6_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (we && widx == 3'd6) |=> status[12:11] == $past(wdata[1:0]));

    // R7: without a write the register file keeps its contents
    p_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(regs_flat));

endmodule

// File: rtl/cmd_packet_framer.sv
`timescale 1ns/1ps
module cmd_packet_framer
    import cpf_pkg::*;
#(
    parameter  int MAX_WORDS = 16,
    localparam int CNT_W     = $clog2(MAX_WORDS + 1),
    localparam int IDX_W     = $clog2(MAX_WORDS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic [31:0]                 in_data,
    output logic                        in_ready,
    output logic                        pkt_valid,
    input  logic                        pkt_ready,
    output logic [CNT_W-1:0]            pkt_len,
    output logic [MAX_WORDS*32-1:0]     pkt_words,
    output logic                        xfer_start,
    output logic                        xfer_read,
    output logic [31:0]                 xfer_pos,
    output logic [31:0]                 xfer_size,
    input  logic                        xfer_wr_active,
    output logic                        xfer_data_valid,
    output logic [31:0]                 xfer_data,
    output logic [255:0]                attr_regs,
    output logic [12:0]                 status_low
);

    typedef struct packed {
        logic [CNT_W-1:0]                idx;
        logic                            odd;
        pkt_kind_e                       kind;
        logic [3:0]                      extra;
        logic [MAX_WORDS-1:0][WORD_W-1:0] words;
        logic                            pkt_valid;
        logic [CNT_W-1:0]                pkt_len;
        logic                            xs;
        logic                            xr;
        logic [WORD_W-1:0]               xpos;
        logic [WORD_W-1:0]               xsize;
    } frm_state_t;

    frm_state_t s_d, s_q;

    pkt_kind_e  dec_kind;
    logic [3:0] dec_extra;
    logic       take;
    logic       is_term;
    logic       done;
    logic       attr_we;

    cpf_len_decode u_dec (
        .opcode (in_data[31:24]),
        .kind   (dec_kind),
        .extra  (dec_extra)
    );

    cpf_attr_file u_attr (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (attr_we),
        .widx      (in_data[26:24]),
        .wdata     (in_data),
        .regs_flat (attr_regs),
        .status    (status_low)
    );

    assign in_ready        = xfer_wr_active | ~s_q.pkt_valid | pkt_ready;
    assign take            = in_valid & in_ready & ~xfer_wr_active;
    assign is_term         = (in_data & TERM_MASK) == TERM_VAL;
    assign xfer_data_valid = in_valid & xfer_wr_active;
    assign xfer_data       = in_data;

    always_comb begin
        s_d     = s_q;
        s_d.xs  = 1'b0;
        attr_we = 1'b0;
        done    = 1'b0;
        if (s_q.pkt_valid && pkt_ready) begin
            s_d.pkt_valid = 1'b0;
        end
        if (take) begin
            s_d.odd = ~s_q.odd;
            if (s_q.idx == '0) begin
                // first word of a command
                s_d.words[0] = in_data;
                s_d.kind     = dec_kind;
                s_d.extra    = dec_extra;
                s_d.odd      = 1'b1;
                if (dec_kind == K_ATTR) begin
                    attr_we = 1'b1;
                end else if (dec_kind == K_FIXED && dec_extra == 4'd0) begin
                    s_d.pkt_valid = 1'b1;
                    s_d.pkt_len   = CNT_W'(1);
                end else begin
                    s_d.idx = CNT_W'(1);
                end
            end else begin
                if (s_q.idx < CNT_W'(MAX_WORDS)) begin
                    s_d.words[s_q.idx[IDX_W-1:0]] = in_data;
                    s_d.idx = s_q.idx + CNT_W'(1);
                end
                unique case (s_q.kind)
                    K_FIXED:  done = (s_q.idx == CNT_W'(s_q.extra));
                    K_STRIP1: done = is_term && (s_q.idx >= CNT_W'(3));
                    K_STRIP2: done = is_term && (s_q.idx >= CNT_W'(4)) && !s_q.odd;
                    K_IMAGE: begin
                        if (s_q.idx == CNT_W'(2)) begin
                            s_d.xs    = 1'b1;
                            s_d.xr    = (s_q.words[0][31:29] == 3'b110);
                            s_d.xpos  = s_q.words[1];
                            s_d.xsize = in_data;
                            s_d.idx   = '0;
                        end
                    end
                    default: done = 1'b0;
                endcase
                if (done) begin
                    s_d.pkt_valid = 1'b1;
                    s_d.pkt_len   = (s_q.idx == CNT_W'(MAX_WORDS)) ? CNT_W'(MAX_WORDS)
                                                                  : s_q.idx + CNT_W'(1);
                    s_d.idx       = '0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pkt_valid  = s_q.pkt_valid;
    assign pkt_len    = s_q.pkt_len;
    assign pkt_words  = s_q.words;
    assign xfer_start = s_q.xs;
    assign xfer_read  = s_q.xr;
    assign xfer_pos   = s_q.xpos;
    assign xfer_size  = s_q.xsize;

    // R5: a stalled packet keeps its contents and stays offered
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && !pkt_ready) |=> (pkt_valid && $stable(pkt_words) && $stable(pkt_len)));

    // R5: no parsing progress while a packet is stalled
    p_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && !pkt_ready && !xfer_wr_active) |=> $stable(s_q.idx));

    // R4: emitted length never exceeds the buffer
    p_len_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> (pkt_len != '0 && pkt_len <= CNT_W'(MAX_WORDS)));

    // R12: transfer start is a single-cycle pulse
    p_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |=> !xfer_start);

    // R6: an image command never produces a drawing packet
    p_img_nopkt_r6: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |-> !pkt_valid);

    // R11: routed words leave the parser untouched
    p_bypass_r11: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_wr_active |=> ($stable(s_q.idx) && !$rose(pkt_valid)));

    // R7: an attribute word is not emitted
    p_attr_nopkt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (take && s_q.idx == '0 && in_data[31:27] == 5'b11100) |=> !pkt_valid);

endmodule

// File: tb/cmd_packet_framer_tb_top.sv
`timescale 1ns/1ps
module cmd_packet_framer_tb_top;

    localparam int MAXW  = 16;
    localparam int CW    = $clog2(MAXW + 1);
    localparam logic [31:0] TERM = 32'h5ABC_5DEF;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [31:0]       in_data = '0;
    logic              in_ready;
    logic              pkt_valid;
    logic              pkt_ready = 1'b1;
    logic [CW-1:0]     pkt_len;
    logic [MAXW*32-1:0] pkt_words;
    logic              xfer_start, xfer_read;
    logic [31:0]       xfer_pos, xfer_size;
    logic              xfer_wr_active = 1'b0;
    logic              xfer_data_valid;
    logic [31:0]       xfer_data;
    logic [255:0]      attr_regs;
    logic [12:0]       status_low;

    always #10 clk = ~clk;   // 50 MHz

    cmd_packet_framer #(.MAX_WORDS(MAXW)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
        .pkt_len(pkt_len), .pkt_words(pkt_words), .xfer_start(xfer_start),
        .xfer_read(xfer_read), .xfer_pos(xfer_pos), .xfer_size(xfer_size),
        .xfer_wr_active(xfer_wr_active), .xfer_data_valid(xfer_data_valid),
        .xfer_data(xfer_data), .attr_regs(attr_regs), .status_low(status_low)
    );

    int n_chk = 0, n_fail = 0;
    int pkts_seen = 0, xfers_seen = 0;
    int exp_len[$];
    logic [MAXW*32-1:0] exp_pkt[$];
    logic [31:0] seq [0:63];
    int seq_n, exp_n;
    bit stall_en = 1'b0;
    logic ex_read;
    logic [31:0] ex_pos, ex_size;
    logic [10:0] m_a1 = '0;
    logic [1:0]  m_a6 = '0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int ext_of(input logic [7:0] op);
        if (op == 8'h02) return 2;
        if (op inside {[8'h20:8'h23]}) return 3;
        if (op inside {[8'h24:8'h27]}) return 6;
        if (op inside {[8'h28:8'h2B]}) return 4;
        if (op inside {[8'h2C:8'h2F], [8'h34:8'h37]}) return 8;
        if (op inside {[8'h30:8'h33]}) return 5;
        if (op inside {[8'h38:8'h3B]}) return 7;
        if (op inside {[8'h3C:8'h3F]}) return 11;
        if (op inside {[8'h40:8'h47], [8'h60:8'h63], [8'h74:8'h77], [8'h7C:8'h7F]}) return 2;
        if (op inside {[8'h50:8'h57], [8'h64:8'h67], 8'h80}) return 3;
        if (op inside {[8'h68:8'h6B], [8'h70:8'h73], [8'h78:8'h7B]}) return 1;
        return 0;
    endfunction

    function automatic logic [31:0] nonterm();
        return $urandom & 32'h4FFF_4FFF;
    endfunction

    task automatic build_fixed(input logic [7:0] op);
        seq_n = 1 + ext_of(op);
        seq[0] = {op, 24'($urandom)};
        for (int k = 1; k < seq_n; k++) seq[k] = $urandom;
        exp_n = seq_n;
    endtask

    task automatic build_strip(input logic [7:0] op, input int cnt, input bit fake);
        seq_n = op[4] ? (5 + 2 * cnt) : (4 + cnt);
        seq[0] = {op, 24'($urandom)};
        for (int k = 1; k < seq_n - 1; k++) seq[k] = nonterm();
        if (fake && !op[4]) seq[2] = TERM;
        if (fake && op[4] && cnt > 0) seq[5] = TERM;
        seq[seq_n - 1] = TERM;
        exp_n = (seq_n > MAXW) ? MAXW : seq_n;
    endtask

    task automatic send_word(input logic [31:0] w);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = w;
        #5;
        while (!in_ready) begin
            @(negedge clk);
            #5;
        end
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic push_exp();
        logic [MAXW*32-1:0] ew;
        ew = '0;
        for (int k = 0; k < exp_n; k++) ew[k*32 +: 32] = seq[k];
        if (exp_n > 0) begin
            exp_len.push_back(exp_n);
            exp_pkt.push_back(ew);
        end
    endtask

    task automatic send_range(input int a, input int b);
        for (int k = a; k < b; k++) send_word(seq[k]);
    endtask

    task automatic send_all();
        push_exp();
        send_range(0, seq_n);
    endtask

    task automatic drain();
        for (int k = 0; k < 50 && exp_len.size() != 0; k++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // consumer handshake driver
    initial forever begin
        @(negedge clk);
        pkt_ready = stall_en ? ($urandom % 4 != 0) : 1'b1;
    end

    // output monitor
    initial begin
        bit held = 0;
        logic [MAXW*32-1:0] hw;
        logic [CW-1:0] hl;
        forever begin
            @(negedge clk);
            #6;
            if (rst_n) begin
                if (held) begin
                    chk(pkt_valid && pkt_words == hw && pkt_len == hl, "R5 held packet changed",
                        64'(pkt_len), 64'(hl));
                    held = 0;
                end
                if (pkt_valid && !pkt_ready) begin
                    held = 1; hw = pkt_words; hl = pkt_len;
                end
                if (pkt_valid && pkt_ready) begin
                    pkts_seen++;
                    if (exp_len.size() == 0) begin
                        chk(0, "R1 unexpected packet", 64'(pkt_words[31:0]), 64'(0));
                    end else begin
                        int el;
                        logic [MAXW*32-1:0] ew;
                        bit bad;
                        el = exp_len.pop_front();
                        ew = exp_pkt.pop_front();
                        bad = 0;
                        for (int k = 0; k < el; k++)
                            if (pkt_words[k*32 +: 32] != ew[k*32 +: 32]) bad = 1;
                        chk(pkt_len == CW'(el) && !bad, "R1/R2/R3/R4 packet content",
                            {32'(pkt_len), pkt_words[31:0]}, {32'(el), ew[31:0]});
                    end
                end
                if (xfer_start) begin
                    xfers_seen++;
                    chk(xfer_read == ex_read && xfer_pos == ex_pos && xfer_size == ex_size,
                        "R6 transfer fields", {31'(0), xfer_read, xfer_pos}, {31'(0), ex_read, ex_pos});
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        int p0, x0;
        logic [7:0] fixed_ops [0:22];
        void'($urandom(32'd4242));
        fixed_ops = '{8'h02, 8'h20, 8'h24, 8'h28, 8'h2C, 8'h30, 8'h34, 8'h38, 8'h3C,
                      8'h40, 8'h50, 8'h60, 8'h64, 8'h68, 8'h6C, 8'h70, 8'h74, 8'h78,
                      8'h7C, 8'h80, 8'h00, 8'hFF, 8'hE8};
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);

        // R9 reset state
        chk(!pkt_valid && !xfer_start, "R9 outputs idle", {pkt_valid, xfer_start}, 0);
        chk(status_low == 13'h0, "R9 status", 64'(status_low), 0);
        for (int i = 0; i < 8; i++)
            chk(attr_regs[i*32 +: 32] == {8'hE0 + 8'(i), 24'h0}, "R9 attribute reset",
                64'(attr_regs[i*32 +: 32]), 64'({8'hE0 + 8'(i), 24'h0}));

        // R1 every fixed-length group
        foreach (fixed_ops[i]) begin
            build_fixed(fixed_ops[i] | 8'(i % 4 == 1 && fixed_ops[i] >= 8'h20 && fixed_ops[i] < 8'h80 ? 1 : 0));
            send_all();
        end
        drain();
        chk(exp_len.size() == 0, "R1 all fixed packets seen", 64'(exp_len.size()), 0);

        // R2 strip with terminator pattern at index 2 (untested position)
        build_strip(8'h4A, 2, 1'b1); send_all();
        build_strip(8'h48, 0, 1'b0); send_all();
        // R3 strip pairs with terminator pattern at odd index 5
        build_strip(8'h5C, 2, 1'b1); send_all();
        build_strip(8'h58, 0, 1'b0); send_all();
        // R4 overlong strip: 24 words, 16 kept
        build_strip(8'h4C, 20, 1'b0); send_all();
        build_strip(8'h5A, 8, 1'b0); send_all();
        drain();
        chk(exp_len.size() == 0, "R2/R3/R4 strips seen", 64'(exp_len.size()), 0);

        // R10 partial packet waits
        p0 = pkts_seen;
        build_fixed(8'h28);
        push_exp();
        send_range(0, 2);
        repeat (10) @(negedge clk);
        #6 chk(!pkt_valid && pkts_seen == p0, "R10 no early packet", 64'(pkts_seen), 64'(p0));
        send_range(2, seq_n);
        drain();
        chk(pkts_seen == p0 + 1, "R10 packet after completion", 64'(pkts_seen), 64'(p0 + 1));

        // R7 / R8 attribute writes
        p0 = pkts_seen;
        send_word(32'hE100_05A5); m_a1 = 11'h5A5;
        send_word(32'hE6FF_FFFE); m_a6 = 2'b10;
        send_word(32'hE312_3456);
        repeat (3) @(negedge clk);
        #6;
        chk(status_low == {m_a6, m_a1}, "R8 status bits", 64'(status_low), 64'({m_a6, m_a1}));
        chk(attr_regs[3*32 +: 32] == 32'hE312_3456, "R7 attribute 3", 64'(attr_regs[96 +: 32]), 64'h E3123456);
        chk(pkts_seen == p0, "R7 attribute not emitted", 64'(pkts_seen), 64'(p0));

        // R6 image read
        x0 = xfers_seen; p0 = pkts_seen;
        ex_read = 1'b1; ex_pos = 32'h0012_0034; ex_size = 32'h0040_0020;
        send_word(32'hC000_0000); send_word(ex_pos); send_word(ex_size);
        repeat (3) @(negedge clk);
        chk(xfers_seen == x0 + 1 && pkts_seen == p0, "R6 read start", 64'(xfers_seen), 64'(x0 + 1));

        // R6 image write, then R11 routed data
        x0 = xfers_seen;
        ex_read = 1'b0; ex_pos = 32'h0001_0002; ex_size = 32'h0002_0004;
        send_word(32'hA0AB_CDEF); send_word(ex_pos); send_word(ex_size);
        repeat (2) @(negedge clk);
        chk(xfers_seen == x0 + 1, "R6 write start", 64'(xfers_seen), 64'(x0 + 1));
        @(negedge clk);
        xfer_wr_active = 1'b1;
        for (int k = 0; k < 4; k++) begin
            logic [31:0] w;
            w = (k == 0) ? 32'h0200_0000 : $urandom;
            @(negedge clk);
            in_valid = 1'b1; in_data = w;
            #5 chk(xfer_data_valid && in_ready && xfer_data == w, "R11 routed word",
                   64'(xfer_data), 64'(w));
            @(posedge clk);
            #1 in_valid = 1'b0;
        end
        @(negedge clk);
        xfer_wr_active = 1'b0;
        #6 chk(!pkt_valid && pkts_seen == p0, "R11 parser untouched", 64'(pkts_seen), 64'(p0));
        build_fixed(8'h64); send_all();
        drain();
        chk(pkts_seen == p0 + 1 && exp_len.size() == 0, "R11 framing resumes",
            64'(pkts_seen), 64'(p0 + 1));

        // random traffic with consumer stalls (R5, R12 and back-to-back handoff)
        stall_en = 1'b1;
        for (int it = 0; it < 250; it++) begin
            int r;
            logic [7:0] op;
            r = $urandom % 10;
            if (r < 2) begin
                build_strip(8'h48 | 8'($urandom % 8), $urandom % 16, $urandom % 2); send_all();
            end else if (r < 4) begin
                build_strip(8'h58 | 8'($urandom % 8), $urandom % 8, $urandom % 2); send_all();
            end else if (r == 9) begin
                logic [31:0] aw;
                aw = $urandom;
                if (aw[0]) begin send_word({8'hE1, aw[23:0]}); m_a1 = aw[10:0]; end
                else begin send_word({8'hE6, aw[23:0]}); m_a6 = aw[1:0]; end
            end else begin
                do op = 8'($urandom);
                while (op inside {[8'hA0:8'hDF], [8'hE0:8'hE7], [8'h48:8'h4F], [8'h58:8'h5F]});
                build_fixed(op); send_all();
            end
        end
        stall_en = 1'b0;
        drain();
        chk(exp_len.size() == 0, "R1/R5 random packets all delivered", 64'(exp_len.size()), 0);
        chk(status_low == {m_a6, m_a1}, "R8 status after random", 64'(status_low), 64'({m_a6, m_a1}));

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule